// File: doc/BRIEF.md
# Timeout Capacitor Sampling Sequencer

This block sizes a watchdog period by timing an external element exactly once. When the supervised reset is released, the block raises a ramp enable. It then counts whole base periods of a divided clock until a threshold comparator reports that the ramp has crossed. The comparator arrives here as a digital input. The number of complete periods is latched and held for the watchdog for the rest of operation. The hold lasts until the block's own reset.

There are four special outcomes:
- If reset reasserts part way through a run, the run is dropped. The next release starts a fresh run from zero.
- A measurement below a small limit means the element is open or missing. It is stored as a zero-timeout code.
- A measurement that reaches a large limit is stored as an infinite-timeout code, and the counter stops there.
- A timing pin tied to ground also gives the infinite code at once, with no ramp.

Top module: `tcs_sample_seq`

## Requirements
- R1: After reset, ramp_enable, count_valid, timeout_zero, timeout_infinite are 0 and period_count is 0.
- R2: A reset_release pulse seen while reset_active is low and no result is held starts a run: ramp_enable is 1 in the following cycle. A pulse seen while reset_active is high starts nothing.
- R3: When ramp_done is seen after K clock edges of ramp_enable high, period_count becomes floor(K / DIV) and count_valid rises in the next cycle.
- R4: A finished count below ZERO_LIM sets timeout_zero and stores period_count = 0. A count equal to ZERO_LIM is stored as-is with no flag.
- R5: If ramp_done has not arrived when K reaches INF_LIM*DIV, the run ends. timeout_infinite is set and period_count holds INF_LIM. ramp_done on the last edge before that still wins, giving INF_LIM-1.
- R6: reset_active high during a run drops ramp_enable in the next cycle and leaves count_valid low. The next release counts again from zero.
- R7: A release seen with pin_grounded high stores the infinite code at once (count_valid=1, timeout_infinite=1, period_count=INF_LIM) without raising ramp_enable.
- R8: count_valid is low before and during a run. Once high, the flags and period_count stay constant, and later release, reset_active or ramp_done inputs have no effect.
- R9: ramp_done while no run is active changes no output.
- R10: ramp_enable is high only while a run is in progress. It falls in the cycle after completion or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reset_release | input | 1 | One-cycle strobe: supervised reset has been released |
| reset_active | input | 1 | Level: supervised reset is asserted |
| ramp_done | input | 1 | Ramp comparator has crossed its threshold |
| pin_grounded | input | 1 | Timing pin is tied to ground |
| ramp_enable | output | 1 | Ramp current source enable |
| period_count | output | CNT_W | Stored count of whole base periods |
| count_valid | output | 1 | Stored result is held |
| timeout_zero | output | 1 | Stored result is the zero-timeout code |
| timeout_infinite | output | 1 | Stored result is the infinite-timeout code |

## Verification
A prescaler phase that is not cleared between runs shows up as a period_count one off from floor(K/DIV). This is visible in the first cycle of count_valid after a restarted run. A wrong control state shows at once on ramp_enable. It either stays high after an abort or finish, or rises when a result is already held. Both are visible one cycle after the input that caused them. A bad classification shows on the cycle the result is loaded. It appears as the wrong flag, or as a non-zero count beside timeout_zero.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_HELD = 2'd2
  } sq_state_t;
endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  generate
    if (DIV == 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      logic [PW-1:0] phase;
      assign tick = run && (phase == LAST);
      always_ff @(posedge clk) begin
        if (rst || clear) phase <= '0;
        else if (run) phase <= tick ? '0 : phase + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tcs_period_ctr.sv
module tcs_period_ctr #(
  parameter int CNT_W = 6,
  parameter int LIMIT = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             last_step
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] PRE = CNT_W'(LIMIT - 1);

  assign last_step = tick && (count == PRE);

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (tick && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/tcs_result_reg.sv
module tcs_result_reg #(
  parameter int CNT_W    = 6,
  parameter int ZERO_LIM = 3,
  parameter int INF_LIM  = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             force_inf,
  input  logic [CNT_W-1:0] raw_count,
  output logic [CNT_W-1:0] period_count,
  output logic             count_valid,
  output logic             timeout_zero,
  output logic             timeout_infinite
);
  function automatic logic [CNT_W+1:0] classify(input logic [CNT_W-1:0] c, input logic inf);
    logic [CNT_W-1:0] v;
    logic z, i;
    i = inf || (int'(c) >= INF_LIM);
    z = !i && (int'(c) < ZERO_LIM);
    if (i)      v = CNT_W'(INF_LIM);
    else if (z) v = '0;
    else        v = c;
    return {z, i, v};
  endfunction

  logic [CNT_W+1:0] cls;
  assign cls = classify(raw_count, force_inf);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_count     <= '0;
      count_valid      <= 1'b0;
      timeout_zero     <= 1'b0;
      timeout_infinite <= 1'b0;
    end else if (load && !count_valid) begin
      period_count     <= cls[CNT_W-1:0];
      timeout_infinite <= cls[CNT_W];
      timeout_zero     <= cls[CNT_W+1];
      count_valid      <= 1'b1;
    end
  end
endmodule

// File: rtl/tcs_sample_seq.sv
module tcs_sample_seq #(
  parameter int DIV      = 4,
  parameter int ZERO_LIM = 3,
  parameter int INF_LIM  = 40,
  parameter int CNT_W    = $clog2(INF_LIM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reset_release,
  input  logic             reset_active,
  input  logic             ramp_done,
  input  logic             pin_grounded,
  output logic             ramp_enable,
  output logic [CNT_W-1:0] period_count,
  output logic             count_valid,
  output logic             timeout_zero,
  output logic             timeout_infinite
);
  import tcs_pkg::*;

  sq_state_t        state, state_nx;
  logic             run_active, start_ok, abort_run, cmp_end, sat_end, finish_load, force_inf;
  logic             tick, last_step, live;
  logic [CNT_W-1:0] raw_count;

  assign run_active  = (state == SQ_RUN);
  assign start_ok    = (state == SQ_IDLE) && reset_release && !reset_active;
  assign abort_run   = run_active && reset_active;
  assign live        = run_active && !reset_active && !ramp_done;
  assign cmp_end     = run_active && !reset_active && ramp_done;
  assign sat_end     = live && last_step;
  assign finish_load = cmp_end || sat_end || (start_ok && pin_grounded);
  assign force_inf   = sat_end || (start_ok && pin_grounded);
  assign ramp_enable = run_active;

  always_comb begin
    state_nx = state;
    case (state)
      SQ_IDLE: if (start_ok) state_nx = pin_grounded ? SQ_HELD : SQ_RUN;
      SQ_RUN: begin
        if (abort_run) state_nx = SQ_IDLE;
        else if (cmp_end || sat_end) state_nx = SQ_HELD;
      end
      default: state_nx = SQ_HELD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SQ_IDLE;
    else     state <= state_nx;
  end

  tcs_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .clear(!run_active), .run(live), .tick(tick)
  );

  tcs_period_ctr #(.CNT_W(CNT_W), .LIMIT(INF_LIM)) u_ctr (
    .clk(clk), .rst(rst), .clear(!run_active), .tick(tick),
    .count(raw_count), .last_step(last_step)
  );

  tcs_result_reg #(.CNT_W(CNT_W), .ZERO_LIM(ZERO_LIM), .INF_LIM(INF_LIM)) u_res (
    .clk(clk), .rst(rst), .load(finish_load), .force_inf(force_inf),
    .raw_count(raw_count), .period_count(period_count), .count_valid(count_valid),
    .timeout_zero(timeout_zero), .timeout_infinite(timeout_infinite)
  );
endmodule

// File: rtl/tcs_seq_chk.sv
module tcs_seq_chk #(
  parameter int CNT_W   = 6,
  parameter int INF_LIM = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             reset_release,
  input logic             reset_active,
  input logic             ramp_done,
  input logic             pin_grounded,
  input logic             ramp_enable,
  input logic [CNT_W-1:0] period_count,
  input logic             count_valid,
  input logic             timeout_zero,
  input logic             timeout_infinite,
  input logic             run_active,
  input logic             finish_load
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!ramp_enable && !count_valid && !timeout_zero && !timeout_infinite && period_count == '0));

  // R2
  start_run_chk: assert property (@(posedge clk) disable iff (rst)
    (reset_release && !reset_active && !pin_grounded && !ramp_enable && !count_valid) |=> ramp_enable);

  // R4
  zero_code_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_zero |-> (period_count == '0 && count_valid));

  // R5
  count_cap_chk: assert property (@(posedge clk) disable iff (rst)
    int'(period_count) <= INF_LIM);

  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({timeout_zero, timeout_infinite}));

  // R6
  abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp_enable && reset_active) |=> (!ramp_enable && !count_valid));

  // R8
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    count_valid |=> (count_valid && $stable(period_count) && $stable(timeout_zero) && $stable(timeout_infinite)));

  // R10
  run_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(count_valid && ramp_enable));

  // R10
  finish_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (run_active && finish_load) |=> (!ramp_enable && count_valid));
endmodule

bind tcs_sample_seq tcs_seq_chk #(.CNT_W(CNT_W), .INF_LIM(INF_LIM)) u_chk (.*);

// File: tb/tcs_sample_seq_tb.sv
module tcs_sample_seq_tb;
  localparam int DIV = 4, ZL = 3, IL = 40, CW = $clog2(IL + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic rel = 1'b0, ract = 1'b0, rdone = 1'b0, pg = 1'b0;
  logic en, valid, zf, inff;
  logic [CW-1:0] cnt;
  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  tcs_sample_seq #(.DIV(DIV), .ZERO_LIM(ZL), .INF_LIM(IL)) u_dut (
    .clk(clk), .rst(rst), .reset_release(rel), .reset_active(ract),
    .ramp_done(rdone), .pin_grounded(pg), .ramp_enable(en), .period_count(cnt),
    .count_valid(valid), .timeout_zero(zf), .timeout_infinite(inff)
  );

  // behavioural reference: 0 idle, 1 sampling, 2 result held
  int m_mode = 0, m_edges = 0, m_cnt = 0;
  bit m_valid = 0, m_zero = 0, m_inf = 0;

  task automatic m_store(input int c, input bit inf);
    m_valid = 1; m_mode = 2;
    if (inf) begin m_inf = 1; m_cnt = IL; end
    else if (c < ZL) begin m_zero = 1; m_cnt = 0; end
    else m_cnt = c;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_edges = 0; m_cnt = 0; m_valid = 0; m_zero = 0; m_inf = 0;
    end else if (m_mode == 0) begin
      if (rel && !ract) begin
        if (pg) m_store(0, 1);
        else begin m_mode = 1; m_edges = 0; end
      end
    end else if (m_mode == 1) begin
      if (ract) m_mode = 0;
      else if (rdone) m_store(m_edges / DIV, 0);
      else begin
        m_edges++;
        if (m_edges == IL * DIV) m_store(IL, 1);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk(en == (m_mode == 1), "R10 ramp_enable vs model", int'(en), int'(m_mode == 1));
    chk(valid == m_valid, "R8 count_valid vs model", int'(valid), int'(m_valid));
    chk(int'(cnt) == m_cnt, "R3 period_count vs model", int'(cnt), m_cnt);
    chk(zf == m_zero, "R4 timeout_zero vs model", int'(zf), int'(m_zero));
    chk(inff == m_inf, "R5 timeout_infinite vs model", int'(inff), int'(m_inf));
  end

  task automatic do_reset();
    rst = 1; repeat (2) @(negedge clk); rst = 0;
  endtask
  task automatic pulse_rel();
    rel = 1; @(negedge clk); rel = 0;
  endtask
  task automatic ramp_for(input int k);
    repeat (k) @(negedge clk);
    rdone = 1; @(negedge clk); rdone = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0; @(negedge clk);
    cmp_on = 1;
    // R1 reset state
    chk(!en && !valid && !zf && !inff && cnt == 0, "R1 reset state", int'({en, valid, zf, inff}), 0);

    // R9 comparator pulse with no run
    rdone = 1; @(negedge clk); rdone = 0; @(negedge clk);
    chk(!en && !valid, "R9 idle ramp_done ignored", int'({en, valid}), 0);

    // R2 release during reset is ignored
    ract = 1; pulse_rel(); ract = 0;
    chk(!en, "R2 release while reset active", int'(en), 0);
    pulse_rel();
    chk(en, "R2 run started", int'(en), 1);
    ramp_for(23);
    chk(valid && cnt == 5 && !zf && !inff, "R3 floor 23/4", int'(cnt), 5);
    chk(!en, "R10 enable off after finish", int'(en), 0);

    // R8 later inputs ignored
    pulse_rel(); ract = 1; rdone = 1; @(negedge clk); ract = 0; rdone = 0;
    repeat (3) @(negedge clk);
    chk(valid && cnt == 5 && !en, "R8 held result unchanged", int'(cnt), 5);

    // R4 below and at the zero limit
    do_reset(); pulse_rel(); ramp_for(11);
    chk(zf && cnt == 0 && valid, "R4 count 2 gives zero code", int'(zf), 1);
    do_reset(); pulse_rel(); ramp_for(12);
    chk(!zf && cnt == 3 && valid, "R4 count 3 kept", int'(cnt), 3);

    // R5 saturation and last-edge comparator
    do_reset(); pulse_rel(); repeat (170) @(negedge clk);
    chk(inff && cnt == IL && !en, "R5 saturated infinite", int'(cnt), IL);
    do_reset(); pulse_rel(); ramp_for(IL * DIV - 1);
    chk(!inff && cnt == IL - 1, "R5 comparator on last edge", int'(cnt), IL - 1);

    // R6 abort and restart from zero
    do_reset(); pulse_rel(); repeat (10) @(negedge clk);
    ract = 1; @(negedge clk); ract = 0;
    chk(!en && !valid, "R6 abort drops enable", int'({en, valid}), 0);
    repeat (3) @(negedge clk);
    pulse_rel(); ramp_for(21);
    chk(valid && cnt == 5, "R6 restart counts from zero", int'(cnt), 5);

    // R7 grounded pin
    do_reset(); pg = 1; pulse_rel(); pg = 0;
    chk(valid && inff && cnt == IL && !en, "R7 grounded pin infinite", int'(cnt), IL);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule